// File: doc/BRIEF.md
# Byte-Wide Nonvolatile RAM Host Sequencer

This block sits between a synchronous host and a byte-wide parallel nonvolatile RAM. The RAM starts each access on a falling edge of its active-low chip enable and requires a precharge gap with chip enable high after every access. The host issues a request that carries a direction, a 15-bit byte address and write data. The sequencer turns that request into a clocked sequence on the chip-enable, write-enable and output-enable strobes, the address bus and the write-data bus. When the access ends it returns the read byte and a single-cycle completion pulse.

Every interval is a whole number of clock cycles set by a parameter: address setup before chip enable falls, the access window with chip enable low, the address hold after that falling edge, and the precharge gap. Reads and writes take the same number of cycles. Writes always begin with write enable already low when chip enable falls, so output enable stays high for the whole write. The write data bus is driven one way and has a separate enable, so the block needs no tristate logic.

Top module: `nvram_host_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dout_en` and `done` are 0, `mem_addr` is 0 and `req_ready` is 1.
- R2: A request is accepted only when `req_ready` is 1, which happens only in the idle phase. `req_ready` is 0 from the acceptance edge until the completion pulse. A `req_valid` raised while an access is in progress is ignored: it changes no location in memory and does not alter the current access.
- R3: The requested address is on `mem_addr` for at least SETUP_CYC cycles before `mem_ce_n` falls. `mem_ce_n` then stays low for exactly ACCESS_CYC cycles.
- R4: From the falling edge of `mem_ce_n`, `mem_addr` holds the requested address for HOLD_CYC cycles. It is then parked at 0 for the rest of the low window.
- R5: After every rise of `mem_ce_n`, it stays high for at least PRECH_CYC cycles before it can fall again. This holds for reads and writes alike, including back-to-back requests.
- R6: In a write, `mem_we_n` is already 0 during the setup cycle before `mem_ce_n` falls. It is still 0 on the cycle `mem_ce_n` rises, so chip enable ends the write. `mem_oe_n` stays 1 throughout.
- R7: During a write, `mem_dout_en` is 1 and `mem_dout` carries the request data unchanged for as long as `mem_we_n` is 0.
- R8: In a read, `mem_oe_n` is 0 exactly while `mem_ce_n` is 0. `rd_data` takes the value of `mem_din` on the last cycle of the access window and holds it until the next read.
- R9: `done` is a one-cycle pulse. It appears SETUP_CYC+ACCESS_CYC+PRECH_CYC cycles after the acceptance edge, the same for reads and writes.
- R10: A request presented in the same cycle as `done` is accepted at once, with no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dout | output | 8 | Write data to memory |
| mem_dout_en | output | 1 | Write data bus enable |
| mem_din | input | 8 | Read data from memory |

## Verification
Writes and reads run back to back, so a design that skipped or shortened the precharge gap would show a chip-enable high time below the minimum. A design that let write enable fall after chip enable would start the cycle as a read, and the bench catches that as write enable high at the falling edge or output enable low during a write. A request is raised in the middle of an access to a different address, then that address is read back. A sequencer that took requests while busy would corrupt that byte or add a completion pulse. Reading the top and bottom of the address space checks that the address is held for the hold window and then parked, and that the read byte is captured at the end of the access window and not after chip enable rises.

// File: rtl/nvh_pkg.sv
package nvh_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2,
        PH_PRECH  = 2'd3
    } nvh_phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } nvh_req_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dout_en;
    } nvh_strb_t;

    function automatic int unsigned cnt_bits(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Strobe levels for each phase. wr_tail marks the first precharge cycle
    // of a write, in which write enable is kept low so chip enable ends it.
    function automatic nvh_strb_t strobe_for(input nvh_phase_e ph, input logic wr,
                                             input logic wr_tail);
        nvh_strb_t s;
        s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dout_en: 1'b0};
        unique case (ph)
            PH_IDLE: ;
            PH_SETUP: begin
                s.we_n    = ~wr;
                s.dout_en = wr;
            end
            PH_ACCESS: begin
                s.ce_n    = 1'b0;
                s.we_n    = ~wr;
                s.oe_n    = wr;
                s.dout_en = wr;
            end
            PH_PRECH: begin
                s.we_n    = ~(wr & wr_tail);
                s.dout_en = wr & wr_tail;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nvh_phase_timer.sv
module nvh_phase_timer #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvh_seq.sv
module nvh_seq
    import nvh_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned ACCESS_CYC = 4,
    parameter int unsigned PRECH_CYC  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  nvh_req_t   req_in,
    output logic       req_ready,
    output nvh_req_t   cur,
    output nvh_phase_e phase,
    output logic       access_last,
    output nvh_strb_t  strb,
    output logic       done
);
    localparam int unsigned CW = cnt_bits(max3(SETUP_CYC, ACCESS_CYC, PRECH_CYC));
    localparam logic [CW-1:0] SETUP_LD  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] ACCESS_LD = CW'(ACCESS_CYC - 1);
    localparam logic [CW-1:0] PRECH_LD  = CW'(PRECH_CYC - 1);

    nvh_phase_e    phase_q, phase_d;
    logic          t_load, t_expired, tail_q;
    logic [CW-1:0] t_val;

    nvh_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    always_comb begin
        phase_d = phase_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (phase_q)
            PH_IDLE: if (req_valid) begin
                phase_d = PH_SETUP;
                t_load  = 1'b1;
                t_val   = SETUP_LD;
            end
            PH_SETUP: if (t_expired) begin
                phase_d = PH_ACCESS;
                t_load  = 1'b1;
                t_val   = ACCESS_LD;
            end
            PH_ACCESS: if (t_expired) begin
                phase_d = PH_PRECH;
                t_load  = 1'b1;
                t_val   = PRECH_LD;
            end
            PH_PRECH: if (t_expired) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            tail_q  <= 1'b0;
            done    <= 1'b0;
            cur     <= '0;
        end else begin
            phase_q <= phase_d;
            tail_q  <= (phase_q == PH_ACCESS) && (phase_d == PH_PRECH);
            done    <= (phase_q == PH_PRECH) && t_expired;
            if (phase_q == PH_IDLE && req_valid)
                cur <= req_in;
        end
    end

    assign phase       = phase_q;
    assign req_ready   = (phase_q == PH_IDLE);
    assign access_last = (phase_q == PH_ACCESS) && t_expired;
    assign strb        = strobe_for(phase_q, cur.wr, tail_q);

    AST_WE_BEFORE_CE: assert property (@(posedge clk) disable iff (rst)
        ($fell(strb.ce_n) && cur.wr) |-> !strb.we_n);                 // R6
    AST_CE_ENDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($rose(strb.ce_n) && cur.wr) |-> !strb.we_n);                 // R6
    AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !strb.we_n |-> strb.oe_n);                                    // R6
    AST_OE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
        !strb.oe_n |-> !strb.ce_n);                                   // R8
    AST_PRECH_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.ce_n) |=> strb.ce_n);                              // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                              // R9
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && req_valid) |=> $stable(cur));                  // R2

endmodule

// File: rtl/nvh_addr_drv.sv
module nvh_addr_drv
    import nvh_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  nvh_phase_e        phase,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int unsigned HW = cnt_bits(HOLD_CYC);
    localparam logic [HW-1:0] HOLD_N = HW'(HOLD_CYC);

    logic [HW-1:0] hold_q;
    logic          addr_vis;

    always_ff @(posedge clk) begin
        if (rst || phase != PH_ACCESS)
            hold_q <= '0;
        else if (hold_q != HOLD_N)
            hold_q <= hold_q + 1'b1;
    end

    assign addr_vis = (phase == PH_SETUP) || (phase == PH_ACCESS && hold_q < HOLD_N);
    assign mem_addr = addr_vis ? addr_in : '0;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (addr_vis && $past(addr_vis)) |-> $stable(mem_addr));         // R4

endmodule

// File: rtl/nvh_rd_capture.sv
module nvh_rd_capture
    import nvh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (cap_en)
            rd_data <= din;
    end

    AST_RDATA_KEPT: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(rd_data));                                // R8

endmodule

// File: rtl/nvram_host_ctl.sv
module nvram_host_ctl
    import nvh_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned ACCESS_CYC = 4,
    parameter int unsigned HOLD_CYC   = 2,
    parameter int unsigned PRECH_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    nvh_req_t   req_in, cur;
    nvh_phase_e phase;
    nvh_strb_t  strb;
    logic       access_last;

    assign req_in = '{wr: req_write, addr: req_addr, data: req_wdata};

    nvh_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .PRECH_CYC  (PRECH_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_in      (req_in),
        .req_ready   (req_ready),
        .cur         (cur),
        .phase       (phase),
        .access_last (access_last),
        .strb        (strb),
        .done        (done)
    );

    nvh_addr_drv #(.HOLD_CYC(HOLD_CYC)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .addr_in  (cur.addr),
        .mem_addr (mem_addr)
    );

    nvh_rd_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (access_last && !cur.wr),
        .din     (mem_din),
        .rd_data (rd_data)
    );

    assign mem_ce_n    = strb.ce_n;
    assign mem_we_n    = strb.we_n;
    assign mem_oe_n    = strb.oe_n;
    assign mem_dout_en = strb.dout_en;
    assign mem_dout    = strb.dout_en ? cur.data : '0;

    AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dout));      // R7

endmodule

// File: tb/tb_nvram_host_ctl.sv
module tb_nvram_host_ctl;
    localparam int S = 1, A = 4, H = 2, P = 3;
    localparam int LAT = S + A + P + 1;   // negedges from drive to done

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en;
    logic [7:0]  rd_data, mem_dout, mem_din;
    logic [14:0] mem_addr;

    always #4 clk = ~clk;   // 125 MHz

    nvram_host_ctl #(.SETUP_CYC(S), .ACCESS_CYC(A), .HOLD_CYC(H), .PRECH_CYC(P)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model, indexed by the low address byte
    logic [7:0]  model [256];
    logic [14:0] lat_addr = '0;
    logic        lat_wr = 1'b0;
    assign mem_din = (!mem_ce_n && !lat_wr) ? model[lat_addr[7:0]] : 8'h5A;

    // expectations for the access in flight
    logic        exp_wr = 1'b0;
    logic [14:0] exp_addr = '0;
    logic [7:0]  exp_data = '0;

    // bus monitor, sampled at negedges
    logic        prev_ce = 1'b1, prev_we = 1'b1, prev_done = 1'b0;
    logic [14:0] prev_addr = '0;
    int          low_idx = 0, high_cnt = 0;
    bit          had_cycle = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_ce = 1'b1; prev_done = 1'b0; had_cycle = 0; high_cnt = 0;
        end else begin
            if (prev_ce && !mem_ce_n) begin
                lat_addr = mem_addr;
                lat_wr   = !mem_we_n;
                chk(prev_addr == exp_addr, "R3 addr set up before CE fall", prev_addr, exp_addr);
                chk(prev_we == !exp_wr, "R6 WE level before CE fall", prev_we, !exp_wr);
                if (had_cycle) chk(high_cnt >= P, "R5 precharge length", high_cnt, P);
                low_idx = 0;
            end
            if (!mem_ce_n) begin
                if (low_idx < H) chk(mem_addr == exp_addr, "R4 addr hold", mem_addr, exp_addr);
                else             chk(mem_addr == 0, "R4 addr park", mem_addr, 0);
                if (lat_wr) begin
                    chk(mem_oe_n == 1'b1, "R6 OE high in write", mem_oe_n, 1);
                    chk(mem_dout_en && mem_dout == exp_data, "R7 write data",
                        mem_dout, exp_data);
                end else begin
                    chk(mem_oe_n == 1'b0, "R8 OE low in read", mem_oe_n, 0);
                end
                low_idx++;
            end else begin
                if (!prev_ce) begin
                    chk(low_idx == A, "R3 CE low length", low_idx, A);
                    if (lat_wr) begin
                        chk(mem_we_n == 1'b0, "R6 CE rises first", mem_we_n, 0);
                        chk(mem_dout == exp_data, "R7 data at CE rise", mem_dout, exp_data);
                        model[lat_addr[7:0]] = mem_dout;
                    end
                    high_cnt = 0;
                    had_cycle = 1;
                end
                high_cnt++;
                chk(mem_oe_n == 1'b1, "R8 OE high outside CE", mem_oe_n, 1);
            end
            if (done && prev_done) chk(0, "R9 done longer than one cycle", 1, 0);
            prev_ce = mem_ce_n; prev_we = mem_we_n; prev_addr = mem_addr; prev_done = done;
        end
    end

    // one access; entered and left at a negedge (the done cycle)
    task automatic do_op(input bit wr, input logic [14:0] addr, input logic [7:0] wd,
                         input bit intrude, output int lat);
        chk(req_ready == 1'b1, "R10 ready in idle/done cycle", req_ready, 1);
        exp_wr = wr; exp_addr = addr; exp_data = wd;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (intrude && lat == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0077; req_wdata = 8'hEE;
            end
            if (intrude && lat >= 2 && lat < 6)
                chk(req_ready == 1'b0, "R2 busy ready low", req_ready, 0);
            if (intrude && lat == 6) req_valid = 1'b0;
            @(negedge clk);
            lat++;
        end
    endtask

    // {wr, addr, wdata, expected read}
    localparam logic [31:0] VEC [12] = '{
        {1'b1, 15'h0011, 8'h3C, 8'h00},
        {1'b1, 15'h7F22, 8'hC3, 8'h00},
        {1'b1, 15'h4A33, 8'h00, 8'h00},
        {1'b1, 15'h2544, 8'hFF, 8'h00},
        {1'b0, 15'h0011, 8'h00, 8'h3C},
        {1'b0, 15'h7F22, 8'h00, 8'hC3},
        {1'b1, 15'h0011, 8'hA5, 8'h00},
        {1'b0, 15'h4A33, 8'h00, 8'h00},
        {1'b0, 15'h0011, 8'h00, 8'hA5},
        {1'b0, 15'h2544, 8'h00, 8'hFF},
        {1'b1, 15'h7FFF, 8'h81, 8'h00},
        {1'b0, 15'h7FFF, 8'h00, 8'h81}
    };

    initial begin
        int lat;
        logic [7:0] held;
        for (int i = 0; i < 256; i++) model[i] = 8'h66;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset",
            {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(!mem_dout_en && !done && mem_addr == 0 && req_ready, "R1 idle outputs in reset",
            {mem_dout_en, done, req_ready}, 3'b001);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && !done && req_ready, "R1 idle after reset",
            {mem_ce_n, done, req_ready}, 3'b101);

        // table walk, back to back
        for (int i = 0; i < 12; i++) begin
            do_op(VEC[i][31], VEC[i][30:16], VEC[i][15:8], 0, lat);
            chk(lat == LAT, "R9 latency", lat, LAT);
            if (!VEC[i][31])
                chk(rd_data == VEC[i][7:0], "R8 read data", rd_data, VEC[i][7:0]);
        end

        // R8: rd_data held across a write
        held = rd_data;
        do_op(1, 15'h0155, 8'h42, 0, lat);
        chk(rd_data == held, "R8 rd_data held across write", rd_data, held);

        // R2: request during a busy read is ignored
        do_op(0, 15'h0011, 8'h00, 1, lat);
        chk(lat == LAT, "R2 latency with intruding request", lat, LAT);
        chk(rd_data == 8'hA5, "R2 current access unaffected", rd_data, 8'hA5);
        @(negedge clk);
        chk(!done && req_ready, "R2 no extra access after done", done, 0);
        do_op(0, 15'h0077, 8'h00, 0, lat);
        chk(rd_data == 8'h66, "R2 ignored write left location", rd_data, 8'h66);

        // R10: gap of idle cycles then a request still accepted normally
        repeat (4) @(negedge clk);
        chk(mem_ce_n && req_ready, "R10 idle stays quiet", mem_ce_n, 1);
        do_op(0, 15'h0155, 8'h00, 0, lat);
        chk(rd_data == 8'h42 && lat == LAT, "R9 read after idle gap", rd_data, 8'h42);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule